// File: doc/BRIEF.md
# NAND Sector Bit-Error Corrector

This block repairs a sector held in a local buffer once an upstream BCH error-location engine has found the failing bit positions. Each position is an index into the sector, which is treated as one long polynomial. The block turns each index into a 16-bit word address and a bit number inside that word. It then inverts that bit with a read, XOR and write-back. The buffer holds 264 words (512 data bytes plus 16 spare bytes). A host fills and drains it through a single word-wide port.

A correction run starts with a one-cycle start pulse. With that pulse the host gives an error count, a flag that says the sector can be corrected, and up to eight locations. The block checks the whole list before it touches the buffer. If the sector is marked uncorrectable, if the count is too large, or if any listed location falls outside the sector, the run stops with no write and raises an error flag. Otherwise the locations are applied one after another, in slot order, and a done pulse marks the end.

Top module: `nbf_corrector`

## Requirements
- R1: After reset, busy, done and error are all low.
- R2: Location L addresses word 263 − floor(L/16). Location 0 lands in word 263, location 4223 in word 0, and location 3452 in word 48.
- R3: Inside the addressed word, r = L mod 16 selects bit r XOR 8. Polynomial order takes bits 7..0 first and then bits 15..8. Location 3452 flips bit 4, location 0 flips bit 8 and location 4223 flips bit 7.
- R4: A valid run inverts exactly the listed bits and leaves every other buffer bit unchanged. With count 4 and locations 431, 1062, 1909 and 3452, exactly four bits change.
- R5: Locations are applied one at a time from slot 0 upward. Slot i occupies bits [13i+12:13i] of the location bus. Two equal locations in one list cancel, so that bit keeps its original value.
- R6: If the correctable flag is low at start, no buffer word changes, error goes high, and done pulses two cycles after start.
- R7: If the count is above 8, or any location in slots below the count is above 4223, the run aborts before any write, raises error, and pulses done two cycles after start. Slots at or above the count are not checked.
- R8: For a valid run with count n, busy is high from the cycle after start until done. Done is a single-cycle pulse 2 + 2n cycles after the start edge. A count of 0 writes nothing.
- R9: Host writes to the buffer are ignored while busy is high.
- R10: A host read returns the addressed buffer word one cycle after the address is presented. Error holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle run request, taken only while idle |
| err_count_i | input | 5 | Number of listed locations |
| correctable_i | input | 1 | Upstream engine found all errors |
| err_locs_i | input | 104 | Eight 13-bit locations, slot i at bits [13i+12:13i] |
| host_we_i | input | 1 | Host buffer write strobe |
| host_addr_i | input | 9 | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Registered host read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| error_o | output | 1 | Last run aborted |

## Verification
The assertions assume that the host never needs to write during a run: a write that coincides with a correction write must have been blocked. They also assume that every correction write reaches a word whose stored value differs from the written value in exactly one bit, which presumes the buffer was loaded before the run. The stimulus fills all 264 words before each batch of runs and raises start only while busy is low. It draws locations from 0 to 4223. Out-of-range values and over-limit counts are placed deliberately, so each kind of abort is exercised on purpose.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
    localparam int SECT_WORDS = 264;
    localparam int WORD_BITS  = 16;
    localparam int MAX_FIX    = 8;
    localparam int LOC_BITS   = 13;
    localparam int CNT_BITS   = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } nbf_state_e;
endpackage

// File: rtl/nbf_locmap.sv
module nbf_locmap #(
    parameter int WORDS  = 264,
    parameter int WORD_W = 16,
    parameter int LOC_W  = 13,
    parameter int ADDR_W = 9,
    parameter int BIT_W  = 4
) (
    input  logic [LOC_W-1:0]  loc_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BIT_W-1:0]  bitpos_o,
    output logic              valid_o
);
    localparam int              LAST_LOC = WORDS * WORD_W - 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(WORDS - 1);
    localparam logic [BIT_W-1:0]  HALF     = BIT_W'(WORD_W / 2);

    logic [ADDR_W-1:0] word_rank;

    always_comb begin
        word_rank = ADDR_W'(loc_i >> BIT_W);
        addr_o    = TOP_ADDR - word_rank;
        // low byte carries the higher polynomial indices of each word
        bitpos_o  = loc_i[BIT_W-1:0] ^ HALF;
        valid_o   = (int'(loc_i) <= LAST_LOC);
    end
endmodule

// File: rtl/nbf_sector_ram.sv
module nbf_sector_ram #(
    parameter int WORDS  = 264,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [WORD_W-1:0] host_wdata_i,
    output logic [WORD_W-1:0] host_rdata_o,
    input  logic              eng_we_i,
    input  logic [ADDR_W-1:0] eng_addr_i,
    input  logic [WORD_W-1:0] eng_wdata_i,
    output logic [WORD_W-1:0] eng_rdata_o
);
    logic [WORD_W-1:0] mem_q [WORDS];
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (eng_we_i) begin
            mem_q[eng_addr_i] <= eng_wdata_i;
        end else if (host_we_i) begin
            mem_q[host_addr_i] <= host_wdata_i;
        end
        rdata_q <= mem_q[host_addr_i];
    end

    assign host_rdata_o = rdata_q;
    assign eng_rdata_o  = mem_q[eng_addr_i];

    // R9: host port must be gated off whenever the engine writes
    p_no_dual_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we_i && eng_we_i));

    // R4: each correction write changes exactly one stored bit
    p_single_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we_i |-> ($countones(eng_wdata_i ^ mem_q[eng_addr_i]) == 1));

    // R2: engine never targets a word outside the sector
    p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we_i |-> (int'(eng_addr_i) < WORDS));
endmodule

// File: rtl/nbf_ctrl.sv
module nbf_ctrl
    import nbf_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int MAX_ERR = 8,
    parameter int LOC_W   = 13,
    parameter int CNT_W   = 5,
    parameter int ADDR_W  = 9,
    parameter int BIT_W   = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic [CNT_W-1:0]                   count_i,
    input  logic                               correctable_i,
    input  logic [MAX_ERR*LOC_W-1:0]           locs_i,
    input  logic [MAX_ERR-1:0]                 slot_ok_i,
    input  logic [MAX_ERR-1:0][ADDR_W-1:0]     slot_addr_i,
    input  logic [MAX_ERR-1:0][BIT_W-1:0]      slot_bit_i,
    output logic [MAX_ERR-1:0][LOC_W-1:0]      lat_locs_o,
    input  logic [WORD_W-1:0]                  eng_rdata_i,
    output logic                               eng_we_o,
    output logic [ADDR_W-1:0]                  eng_addr_o,
    output logic [WORD_W-1:0]                  eng_wdata_o,
    output logic                               busy_o,
    output logic                               done_o,
    output logic                               error_o
);
    localparam int SEL_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

    typedef struct packed {
        nbf_state_e                     st;
        logic [SEL_W-1:0]               idx;
        logic [CNT_W-1:0]               cnt;
        logic                           corr;
        logic [MAX_ERR-1:0][LOC_W-1:0]  locs;
        logic [WORD_W-1:0]              rd;
        logic                           done;
        logic                           err;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  list_bad;
    logic  abort;
    logic  last_slot;

    always_comb begin
        list_bad = 1'b0;
        for (int i = 0; i < MAX_ERR; i++) begin
            if ((CNT_W'(i) < r_q.cnt) && !slot_ok_i[i]) begin
                list_bad = 1'b1;
            end
        end
        abort     = !r_q.corr || (int'(r_q.cnt) > MAX_ERR) || list_bad;
        last_slot = (CNT_W'(r_q.idx) == (r_q.cnt - CNT_W'(1)));
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.cnt  = count_i;
                    r_d.corr = correctable_i;
                    r_d.locs = locs_i;
                    r_d.idx  = '0;
                    r_d.err  = 1'b0;
                    r_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (abort) begin
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (r_q.cnt == '0) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.st = ST_READ;
                end
            end
            ST_READ: begin
                r_d.rd = eng_rdata_i;
                r_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                if (last_slot) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + SEL_W'(1);
                    r_d.st  = ST_READ;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lat_locs_o  = r_q.locs;
    assign eng_addr_o  = slot_addr_i[r_q.idx];
    assign eng_we_o    = (r_q.st == ST_WRITE);
    assign eng_wdata_o = r_q.rd ^ (WORD_W'(1) << slot_bit_i[r_q.idx]);
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign error_o     = r_q.err;

    // R8: done lasts exactly one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: busy has dropped when done is shown
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: no write unless the latched run was correctable and in limit
    p_write_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we_o |-> (r_q.corr && (int'(r_q.cnt) <= MAX_ERR)));

    // R7: error only ever rises together with the end-of-run pulse
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> done_o);
endmodule

// File: rtl/nbf_corrector.sv
module nbf_corrector
    import nbf_pkg::*;
#(
    parameter int WORDS   = SECT_WORDS,
    parameter int WORD_W  = WORD_BITS,
    parameter int MAX_ERR = MAX_FIX,
    parameter int LOC_W   = LOC_BITS,
    parameter int CNT_W   = CNT_BITS,
    parameter int ADDR_W  = $clog2(WORDS),
    parameter int BIT_W   = $clog2(WORD_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CNT_W-1:0]         err_count_i,
    input  logic                     correctable_i,
    input  logic [MAX_ERR*LOC_W-1:0] err_locs_i,
    input  logic                     host_we_i,
    input  logic [ADDR_W-1:0]        host_addr_i,
    input  logic [WORD_W-1:0]        host_wdata_i,
    output logic [WORD_W-1:0]        host_rdata_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     error_o
);
    logic [MAX_ERR-1:0][LOC_W-1:0]  lat_locs;
    logic [MAX_ERR-1:0]             slot_ok;
    logic [MAX_ERR-1:0][ADDR_W-1:0] slot_addr;
    logic [MAX_ERR-1:0][BIT_W-1:0]  slot_bit;
    logic                           eng_we;
    logic [ADDR_W-1:0]              eng_addr;
    logic [WORD_W-1:0]              eng_wdata;
    logic [WORD_W-1:0]              eng_rdata;
    logic                           host_we_gated;

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
        nbf_locmap #(
            .WORDS (WORDS),
            .WORD_W(WORD_W),
            .LOC_W (LOC_W),
            .ADDR_W(ADDR_W),
            .BIT_W (BIT_W)
        ) u_map (
            .loc_i   (lat_locs[g]),
            .addr_o  (slot_addr[g]),
            .bitpos_o(slot_bit[g]),
            .valid_o (slot_ok[g])
        );
    end

    nbf_ctrl #(
        .WORD_W (WORD_W),
        .MAX_ERR(MAX_ERR),
        .LOC_W  (LOC_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .BIT_W  (BIT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .count_i      (err_count_i),
        .correctable_i(correctable_i),
        .locs_i       (err_locs_i),
        .slot_ok_i    (slot_ok),
        .slot_addr_i  (slot_addr),
        .slot_bit_i   (slot_bit),
        .lat_locs_o   (lat_locs),
        .eng_rdata_i  (eng_rdata),
        .eng_we_o     (eng_we),
        .eng_addr_o   (eng_addr),
        .eng_wdata_o  (eng_wdata),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .error_o      (error_o)
    );

    assign host_we_gated = host_we_i && !busy_o;

    nbf_sector_ram #(
        .WORDS (WORDS),
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we_i   (host_we_gated),
        .host_addr_i (host_addr_i),
        .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o),
        .eng_we_i    (eng_we),
        .eng_addr_i  (eng_addr),
        .eng_wdata_i (eng_wdata),
        .eng_rdata_o (eng_rdata)
    );
endmodule

// File: tb/nbf_corrector_bench.sv
module nbf_corrector_bench;
    localparam int NW = 264;
    localparam int NL = 13;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [4:0]    err_count_i = '0;
    logic          correctable_i = 1'b0;
    logic [103:0]  err_locs_i = '0;
    logic          host_we_i = 1'b0;
    logic [8:0]    host_addr_i = '0;
    logic [15:0]   host_wdata_i = '0;
    logic [15:0]   host_rdata_o;
    logic          busy_o, done_o, error_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] model [NW];

    always #10 clk = ~clk;

    nbf_corrector u_nbf_corrector (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .err_count_i(err_count_i),
        .correctable_i(correctable_i), .err_locs_i(err_locs_i),
        .host_we_i(host_we_i), .host_addr_i(host_addr_i),
        .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic int map_word(int l);
        return 263 - l / 16;
    endfunction
    function automatic int map_bit(int l);
        return (l % 16) ^ 8;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(int a, logic [15:0] d);
        host_we_i = 1'b1; host_addr_i = 9'(a); host_wdata_i = d;
        @(posedge clk); @(negedge clk);
        host_we_i = 1'b0;
    endtask

    task automatic host_read(int a, output logic [15:0] d);
        host_addr_i = 9'(a);
        @(posedge clk); @(negedge clk);
        d = host_rdata_o;
    endtask

    task automatic load_buffer(bit zero);
        for (int a = 0; a < NW; a++) begin
            logic [15:0] v;
            v = zero ? 16'h0 : 16'($urandom);
            model[a] = v;
            host_write(a, v);
        end
    endtask

    task automatic verify_all(string req);
        int bad = 0;
        int first = -1;
        logic [15:0] fa, fe;
        for (int a = 0; a < NW; a++) begin
            logic [15:0] d;
            host_read(a, d);
            if (d !== model[a]) begin
                bad++;
                if (first < 0) begin first = a; fa = d; fe = model[a]; end
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: word %0d actual 0x%0h expected 0x%0h (%0d words differ)",
                     req, first, fa, fe, bad);
        end
    endtask

    // runs one correction; poke_addr >= 0 issues a host write while busy
    task automatic run(int n, bit corr, int locs[NS], int poke_addr, string req);
        int edges = 0;
        bit ok;
        int eff;
        ok = corr && (n <= NS);
        eff = (n <= NS) ? n : 0;
        for (int i = 0; i < NS; i++) begin
            err_locs_i[i*NL +: NL] = NL'(locs[i]);
            if (i < eff && locs[i] > 4223) ok = 0;
        end
        err_count_i = 5'(n); correctable_i = corr; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; edges = 1;
        check({req, " R8 busy after start"}, 32'(busy_o), 32'd1);
        if (poke_addr >= 0) begin
            host_we_i = 1'b1; host_addr_i = 9'(poke_addr); host_wdata_i = ~model[poke_addr];
        end
        while (!done_o && edges < 40) begin
            @(posedge clk); @(negedge clk);
            host_we_i = 1'b0;
            edges++;
        end
        host_we_i = 1'b0;
        check({req, " R8 done latency"}, 32'(edges), ok ? 32'(2 + 2 * n) : 32'd2);
        check({req, " R7 error flag"}, 32'(error_o), ok ? 32'd0 : 32'd1);
        @(posedge clk); @(negedge clk);
        check({req, " R8 done single pulse"}, 32'(done_o), 32'd0);
        if (ok) begin
            for (int i = 0; i < n; i++)
                model[map_word(locs[i])][map_bit(locs[i])] ^= 1'b1;
        end
    endtask

    initial begin
        int locs[NS];
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 busy at reset", 32'(busy_o), 32'd0);
        check("R1 done at reset", 32'(done_o), 32'd0);
        check("R1 error at reset", 32'(error_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 single-location mapping corners on a zero buffer
        load_buffer(1'b1);
        foreach (locs[i]) locs[i] = 0;
        locs[0] = 3452; run(1, 1, locs, -1, "R2");
        host_read(48, d); check("R2 R3 loc 3452 -> word 48 bit 4", 32'(d), 32'h0010);
        locs[0] = 0; run(1, 1, locs, -1, "R2");
        host_read(263, d); check("R2 R3 loc 0 -> word 263 bit 8", 32'(d), 32'h0100);
        locs[0] = 4223; run(1, 1, locs, -1, "R3");
        host_read(0, d); check("R2 R3 loc 4223 -> word 0 bit 7", 32'(d), 32'h0080);
        verify_all("R4 zero buffer after corners");

        // R4 worked example
        load_buffer(1'b0);
        locs[0] = 431; locs[1] = 1062; locs[2] = 1909; locs[3] = 3452;
        run(4, 1, locs, -1, "R4");
        verify_all("R4 four-location example");

        // R5 duplicate cancels
        locs[0] = 777; locs[1] = 777; locs[2] = 12; locs[3] = 0;
        run(3, 1, locs, -1, "R5");
        verify_all("R5 duplicate locations cancel");

        // R6 uncorrectable
        locs[0] = 100; run(4, 0, locs, -1, "R6");
        verify_all("R6 uncorrectable leaves buffer");

        // R7 aborts: count above limit, bad location, bad slot beyond count ignored
        run(9, 1, locs, -1, "R7 count9");
        run(31, 1, locs, -1, "R7 count31");
        locs[2] = 4224; run(3, 1, locs, -1, "R7 badloc");
        verify_all("R7 abort leaves buffer");
        locs[2] = 8191; run(2, 1, locs, -1, "R7 badloc beyond count");
        verify_all("R7 unchecked slot beyond count");

        // R10 error clears on next accepted start; R8 count 0
        run(0, 1, locs, -1, "R10 R8 count0");
        check("R10 error cleared", 32'(error_o), 32'd0);
        verify_all("R8 count zero writes nothing");

        // R9 host write during busy is dropped
        locs[0] = 50; locs[1] = 60;
        run(2, 1, locs, 17, "R9");
        verify_all("R9 host write while busy ignored");

        // random mix
        for (int t = 0; t < 30; t++) begin
            int n;
            bit corr;
            if (t % 10 == 0) load_buffer(1'b0);
            n = $urandom_range(0, 8);
            corr = ($urandom % 8) != 0;
            foreach (locs[i]) locs[i] = $urandom_range(0, 4223);
            if ($urandom % 4 == 0) locs[1] = locs[0];
            if (n > 0 && $urandom % 6 == 0) locs[$urandom_range(0, n - 1)] = 4224 + $urandom_range(0, 3967);
            run(n, corr, locs, ($urandom % 3 == 0) ? int'($urandom_range(0, 263)) : -1, "R4 R5 random");
            if (t % 5 == 4) verify_all("R4 R7 random buffer");
        end
        verify_all("R4 R10 final buffer");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule